// File: doc/BRIEF.md
# Multi-Link Frame Sync and Bank Switch Controller

This block is shared by up to four serial audio bus links. It produces a periodic frame-sync pulse whose spacing software programs. It also lets several links switch their configuration bank in the same frame. Software reaches the block through one 32-bit control/status word on a plain write port with a continuous readback. Each link receives a sync pulse and a bank-switch strobe.

The sync generator does nothing until software requests a period. From then on it counts down from the loaded period and pulses once each time it wraps. For a coordinated switch, each link taking part first sets its arm bit. One write of the go bit then captures the armed set and clears every arm bit at once. The captured links all receive their strobe on the next sync pulse. The period-apply bit and the go bit clear themselves, so software can poll them to see when the hardware has acted.

Top module: `bank_sync_ctrl`

## Requirements
- R1: After reset the control word reads 0. No sync pulse and no bank-switch strobe is active.
- R2: Every write stores write bits 14:0 as the period field P, and the field reads back at bits 14:0. This alone does not change the running sync spacing.
- R3: Writing 1 to bit 15 (apply) loads P into the generator. Bit 15 reads 1 for exactly one cycle after the write and then reads 0. From then on the sync pulse repeats every P+1 cycles.
- R4: Until the first apply request, no sync pulse is produced, even when a nonzero period has been written.
- R5: Writing 1 to bit 16+n sets the arm bit of link n. Writing 0 to an arm bit leaves it set.
- R6: When the go bit (bit 24) is written while at least one arm bit is set (including arm bits set in the same write), all armed links get a one-cycle strobe together on the next sync pulse, in the same cycle as that pulse. Links that were not armed get no strobe. Bit 24 reads 1 until the strobe cycle and reads 0 afterwards.
- R7: A go write that takes effect clears all arm bits at once, from the next cycle on.
- R8: A go write with no arm bit set triggers nothing: no strobe is issued, and bit 24 reads 0.
- R9: A write with bit 24 at 0 does not cancel a pending go. The strobe still fires on the next sync pulse.
- R10: With P = 0 after an apply, a sync pulse occurs on every cycle. All links always see the same sync value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control/status word |
| sync_o | output | NUM_LINKS | Per-link frame-sync pulse |
| bank_sw_o | output | NUM_LINKS | Per-link bank-switch strobe |

## Verification
The bench builds the block with its defaults: four links and a 15-bit period. This lets it drive the all-links arm pattern, single links and sparse patterns such as links 0 and 2. The period table runs from 0 through 0x176F. It covers the every-cycle case, the shortest nonzero spacing and the nominal period of 6000 cycles, all within one run.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_PER_W = 15;
  localparam int APPLY_BIT = 15;
  localparam int ARM_LSB   = 16;
  localparam int MAX_LINKS = 4;
  localparam int GO_BIT    = 24;
endpackage

// File: rtl/bsc_sync_gen.sv
module bsc_sync_gen #(
  parameter int PERIOD_W = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                apply_set_i,
  output logic                apply_o,
  output logic                sync_o
);
  logic                apply_q, running_q;
  logic [PERIOD_W-1:0] active_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      apply_q   <= 1'b0;
      running_q <= 1'b0;
      active_q  <= '0;
      cnt_q     <= '0;
    end else begin
      if (apply_set_i)  apply_q <= 1'b1;
      else if (apply_q) apply_q <= 1'b0;
      if (apply_q) begin
        active_q  <= period_i;
        cnt_q     <= period_i;
        running_q <= 1'b1;
      end else if (running_q) begin
        cnt_q <= (cnt_q == '0) ? active_q : cnt_q - 1'b1;
      end
    end
  end

  // apply cycle reloads and suppresses the pulse
  assign sync_o  = running_q && (cnt_q == '0) && !apply_q;
  assign apply_o = apply_q;

  a_r3_apply_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_q && !apply_set_i |=> !apply_q);
  a_r3_pulse_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o && (active_q != '0) |=> !sync_o);
  a_r4_start_on_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_q) |-> $past(apply_q));
endmodule

// File: rtl/bsc_arm_ctrl.sv
module bsc_arm_ctrl #(
  parameter int NUM_LINKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [NUM_LINKS-1:0] arm_wr_i,
  input  logic                 go_wr_i,
  input  logic                 sync_i,
  output logic [NUM_LINKS-1:0] arm_o,
  output logic                 go_o,
  output logic [NUM_LINKS-1:0] bank_sw_o
);
  logic [NUM_LINKS-1:0] arm_q, snap_q, arm_all;
  logic                 go_q, go_req, fire;

  assign arm_all = arm_q | (wr_i ? arm_wr_i : '0);
  assign go_req  = wr_i && go_wr_i;
  assign fire    = go_q && sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      snap_q <= '0;
      go_q   <= 1'b0;
    end else if (go_req && (|arm_all)) begin
      arm_q  <= '0;
      snap_q <= (fire ? '0 : snap_q) | arm_all;
      go_q   <= 1'b1;
    end else begin
      arm_q <= arm_all;
      if (fire) begin
        go_q   <= 1'b0;
        snap_q <= '0;
      end
    end
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_strobe
    assign bank_sw_o[i] = fire && snap_q[i];
  end

  assign arm_o = arm_q;
  assign go_o  = go_q;

  a_r6_strobe_on_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_sw_o) |-> sync_i);
  a_r6_go_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_sw_o) && !go_req |=> !go_q);
  a_r7_arm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_req && (|arm_all) |=> arm_q == '0);
  a_r8_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_req && (arm_all == '0) && !go_q |=> !go_q);
  a_r9_go_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q && !sync_i |=> go_q);
endmodule

// File: rtl/bank_sync_ctrl.sv
module bank_sync_ctrl
  import bsc_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int PERIOD_W  = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic [NUM_LINKS-1:0] sync_o,
  output logic [NUM_LINKS-1:0] bank_sw_o
);
  logic [PERIOD_W-1:0]  period_q;
  logic                 apply, sync, go;
  logic [NUM_LINKS-1:0] arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      period_q <= '0;
    else if (wr_en_i) period_q <= wr_data_i[PERIOD_W-1:0];
  end

  bsc_sync_gen #(.PERIOD_W(PERIOD_W)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_i    (period_q),
    .apply_set_i (wr_en_i && wr_data_i[APPLY_BIT]),
    .apply_o     (apply),
    .sync_o      (sync)
  );

  bsc_arm_ctrl #(.NUM_LINKS(NUM_LINKS)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .arm_wr_i  (wr_data_i[ARM_LSB +: NUM_LINKS]),
    .go_wr_i   (wr_data_i[GO_BIT]),
    .sync_i    (sync),
    .arm_o     (arm),
    .go_o      (go),
    .bank_sw_o (bank_sw_o)
  );

  assign sync_o = {NUM_LINKS{sync}};

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[PERIOD_W-1:0]         = period_q;
    rd_data_o[APPLY_BIT]            = apply;
    rd_data_o[ARM_LSB +: NUM_LINKS] = arm;
    rd_data_o[GO_BIT]               = go;
  end

  a_r2_period_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[PERIOD_W-1:0] == $past(wr_data_i[PERIOD_W-1:0]));
  a_r10_links_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sync_o) == 0 || $countones(sync_o) == NUM_LINKS);
endmodule

// File: tb/bank_sync_ctrl_tb.sv
`timescale 1ns/1ps
module bank_sync_ctrl_tb;
  localparam int NL = 4;
  localparam logic [31:0] APPLY = 32'h0000_8000;
  localparam logic [31:0] GO    = 32'h0100_0000;
  localparam int NPER = 6;
  localparam logic [14:0] PER_TAB [NPER] = '{15'd3, 15'd0, 15'd1, 15'd10, 15'h176F, 15'd2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NL-1:0] sync, bsw;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  bank_sync_ctrl #(.NUM_LINKS(NL), .PERIOD_W(15)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .sync_o(sync), .bank_sw_o(bsw));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // gap between two consecutive sync pulses, 0 if none seen
  task automatic meas(output int gap);
    int t = 0;
    gap = 0;
    while (sync == '0 && t < 20000) begin @(negedge clk); t++; end
    if (sync == '0) return;
    @(negedge clk); gap = 1;
    while (sync == '0 && gap < 20000) begin @(negedge clk); gap++; end
  endtask

  task automatic go_test(input logic [31:0] base, input logic [3:0] arms, input bit hold_wr, input string req);
    bit fired = 0;
    wr(base | ({28'd0, arms} << 16));
    check("R5 arm set", {28'd0, rd_data[19:16]}, {28'd0, arms});
    wr(base);
    check("R5 arm kept on zero write", {28'd0, rd_data[19:16]}, {28'd0, arms});
    wr(base | GO);
    check("R7 arms cleared", {28'd0, rd_data[19:16]}, 32'd0);
    if (hold_wr && bsw == '0) wr(base);
    for (int i = 0; i < 40 && !fired; i++) begin
      if (bsw != '0) begin
        check(req, {28'd0, bsw}, {28'd0, arms});
        check("R6 strobe with sync", {28'd0, sync}, 32'hF);
        fired = 1;
      end else begin
        if (rd_data[24] !== 1'b1) check("R6 go pending", {31'd0, rd_data[24]}, 32'd1);
        @(negedge clk);
      end
    end
    check(req, {31'd0, fired}, 32'd1);
    @(negedge clk);
    check("R6 go reads 0 after", {31'd0, rd_data[24]}, 32'd0);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (bsw != '0) check("R6 single strobe", {28'd0, bsw}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int gap;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", rd_data, 32'd0);
    check("R1 reset sync", {28'd0, sync}, 32'd0);
    check("R1 reset strobe", {28'd0, bsw}, 32'd0);

    // R4: no sync before apply
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (sync != '0) bad++; end
    wr(32'd3);
    check("R2 period readback", rd_data, 32'd3);
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (sync != '0) bad++; end
    check("R4 idle before apply", bad, 0);

    // table: period, apply, gap = P+1
    for (int k = 0; k < NPER; k++) begin
      wr({17'd0, PER_TAB[k]} | APPLY);
      check("R3 apply reads 1", {31'd0, rd_data[15]}, 32'd1);
      @(negedge clk);
      check("R3 apply self clears", {31'd0, rd_data[15]}, 32'd0);
      meas(gap);
      check(PER_TAB[k] == 0 ? "R10 zero period gap" : "R3 sync gap", gap, int'(PER_TAB[k]) + 1);
    end

    // R2: new period without apply keeps old spacing (2 -> gap 3)
    wr(32'd9);
    check("R2 period stored", {17'd0, rd_data[14:0]}, 32'd9);
    meas(gap);
    check("R2 no apply keeps spacing", gap, 3);

    wr(32'd5 | APPLY);
    go_test(32'd5, 4'b0101, 0, "R6 sparse links");
    go_test(32'd5, 4'b1111, 0, "R6 all links");
    go_test(32'd5, 4'b1000, 1, "R9 pending go survives");

    // R8: go with nothing armed
    wr(32'd5 | GO);
    check("R8 go reads 0", {31'd0, rd_data[24]}, 32'd0);
    bad = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (bsw != '0) bad++; end
    check("R8 no strobe", bad, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule